// File: doc/BRIEF.md
# Programmable PN Scrambler

The block whitens a serial bit stream by combining each incoming bit with a pseudo-random bit drawn from a 24-stage shift register, so that long runs and repeating patterns in the payload do not leave strong spectral lines on the line. The feedback polynomial is programmable: every stage can be tapped independently through a tap mask, and every stage can be loaded from a preset word, so any polynomial up to degree 24 can be used.

Two synchronization styles are offered. In frame mode the generator runs on its own and is restarted from the preset at each frame boundary, marked by a sync pulse. In self mode the register is fed from the scrambled output itself, so a matching receiver locks without any frame marker. Data advances one bit per cycle in which the advance input is high; on all other cycles the block holds.

Top module: `pn_scrambler`

## Requirements
- R1: After reset the output `dout_o` is 0 and a restart is pending, so the first advance cycle in frame mode (`mode_i` = 0) uses `preset_i` as the current register state.
- R2: Stage k is bit k of the state, of `tap_mask_i` and of `preset_i`. The feedback bit is the XOR of all stages whose mask bit is 1. In frame mode each advance cycle sets the output to input XOR feedback, moves stage k to stage k+1 and puts the feedback into stage 0.
- R3: The output is registered: it changes only at a clock edge where `adv_i` is 1 and holds its value, together with the register state, while `adv_i` is 0.
- R4: In frame mode a `sync_i` pulse on any cycle makes the next advance cycle (the same cycle if `adv_i` is 1 then) use `preset_i` as the current state, the preset bits being both tapped for that bit and shifted on.
- R5: In self mode (`mode_i` = 1) each advance cycle sets the output to input XOR feedback and shifts that output bit into stage 0; `sync_i` has no effect and a pending restart is discarded.
- R6: With an all-zero tap mask the output equals the input of the last advance cycle.
- R7: All 24 stages take part: a mask and preset with only stage 23 set invert the first bit after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Advance enable, one bit per high cycle |
| sync_i | input | 1 | Frame boundary pulse (frame mode) |
| mode_i | input | 1 | 0 = frame synchronized, 1 = self synchronized |
| tap_mask_i | input | 24 | Feedback tap select per stage |
| preset_i | input | 24 | Restart value per stage |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Scrambled serial data out |

## Verification
A wrong stage or a dropped tap shows at `dout_o` as soon as that stage is tapped, which is within at most 24 advance cycles of the fault since every value walks through all stages; the bench taps many stages at once so the first miscompare appears within a few bits. A lost or misplaced restart shows on the very first bit after the sync pulse, because that bit is scrambled from the preset. A shift on a cycle without advance shows on the next advance bit as a phase slip of the pseudo-random sequence.

// File: rtl/pn_scr_pkg.sv
package pn_scr_pkg;

    localparam int PN_STAGES_DEF = 24;

    typedef enum logic {
        SYNC_FRAME = 1'b0,
        SYNC_SELF  = 1'b1
    } sync_mode_e;

endpackage

// File: rtl/pn_tap_parity.sv
module pn_tap_parity #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             parity_o
);
    // Running XOR of the masked stages, one link per stage.
    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    for (genvar k = 0; k < WIDTH; k++) begin : g_tap
        assign chain[k+1] = chain[k] ^ (state_i[k] & mask_i[k]);
    end

    assign parity_o = chain[WIDTH];
endmodule

// File: rtl/pn_sync_ctrl.sv
module pn_sync_ctrl
    import pn_scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       sync_i,
    input  sync_mode_e mode_i,
    output logic       reload_o,
    output logic       pending_o
);
    typedef struct packed {
        logic pending;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  reload;

    always_comb begin
        ctrl_d = ctrl_q;
        reload = 1'b0;
        if (mode_i == SYNC_SELF) begin
            ctrl_d.pending = 1'b0;
        end else if (adv_i) begin
            reload         = ctrl_q.pending | sync_i;
            ctrl_d.pending = 1'b0;
        end else if (sync_i) begin
            ctrl_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.pending <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign reload_o  = reload;
    assign pending_o = ctrl_q.pending;
endmodule

// File: rtl/pn_shift_core.sv
module pn_shift_core
    import pn_scr_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             reload_i,
    input  sync_mode_e       mode_i,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             fb_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] state_o,
    output logic             dout_o
);
    typedef struct packed {
        logic [WIDTH-1:0] state;
        logic             dout;
    } core_t;

    core_t core_d, core_q;
    logic  [WIDTH-1:0] cur;
    logic  scr_bit;
    logic  entry_bit;

    always_comb begin
        cur       = reload_i ? preset_i : core_q.state;
        scr_bit   = din_i ^ fb_i;
        entry_bit = (mode_i == SYNC_SELF) ? scr_bit : fb_i;
        core_d    = core_q;
        if (adv_i) begin
            core_d.state = {cur[WIDTH-2:0], entry_bit};
            core_d.dout  = scr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.state <= '0;
            core_q.dout  <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cur_o   = cur;
    assign state_o = core_q.state;
    assign dout_o  = core_q.dout;
endmodule

// File: rtl/pn_scrambler.sv
module pn_scrambler
    import pn_scr_pkg::*;
#(
    parameter int STAGES = PN_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              sync_i,
    input  logic              mode_i,
    input  logic [STAGES-1:0] tap_mask_i,
    input  logic [STAGES-1:0] preset_i,
    input  logic              din_i,
    output logic              dout_o
);
    sync_mode_e        mode;
    logic              reload;
    logic              pending;
    logic              fb;
    logic [STAGES-1:0] cur_state;
    logic [STAGES-1:0] state_q;

    assign mode = sync_mode_e'(mode_i);

    pn_sync_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv_i),
        .sync_i    (sync_i),
        .mode_i    (mode),
        .reload_o  (reload),
        .pending_o (pending)
    );

    pn_tap_parity #(.WIDTH(STAGES)) u_parity (
        .state_i  (cur_state),
        .mask_i   (tap_mask_i),
        .parity_o (fb)
    );

    pn_shift_core #(.WIDTH(STAGES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv_i),
        .reload_i (reload),
        .mode_i   (mode),
        .preset_i (preset_i),
        .fb_i     (fb),
        .din_i    (din_i),
        .cur_o    (cur_state),
        .state_o  (state_q),
        .dout_o   (dout_o)
    );
endmodule

// File: rtl/pn_scrambler_chk.sv
module pn_scrambler_chk #(
    parameter int STAGES = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic              sync_i,
    input logic              mode_i,
    input logic [STAGES-1:0] tap_mask_i,
    input logic [STAGES-1:0] preset_i,
    input logic              din_i,
    input logic              dout_o,
    input logic [STAGES-1:0] state_q,
    input logic              reload,
    input logic              pending
);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(dout_o) && $stable(state_q));

    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !reload |=> state_q[STAGES-1:1] == $past(state_q[STAGES-2:0]));

    assert_frame_fb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !mode_i |=> state_q[0] == (dout_o ^ $past(din_i)));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> state_q[STAGES-1:1] == $past(preset_i[STAGES-2:0]));

    assert_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i && !mode_i && !adv_i |=> pending);

    assert_self_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && mode_i |=> state_q[0] == dout_o);

    assert_self_noreload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> !reload);

    assert_zero_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && (tap_mask_i == '0) |=> dout_o == $past(din_i));
endmodule

bind pn_scrambler pn_scrambler_chk #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv_i),
    .sync_i     (sync_i),
    .mode_i     (mode_i),
    .tap_mask_i (tap_mask_i),
    .preset_i   (preset_i),
    .din_i      (din_i),
    .dout_o     (dout_o),
    .state_q    (state_q),
    .reload     (reload),
    .pending    (pending)
);

// File: tb/pn_scrambler_tb_top.sv
module pn_scrambler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         adv = 1'b0;
    logic         sync = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] mask = '0;
    logic [W-1:0] preset = '0;
    logic         din = 1'b0;
    logic         dout;

    int n_checks = 0;
    int n_fail = 0;

    logic [W-1:0] m_state;
    logic         m_pend;
    logic         m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    pn_scrambler dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .sync_i     (sync),
        .mode_i     (mode),
        .tap_mask_i (mask),
        .preset_i   (preset),
        .din_i      (din),
        .dout_o     (dout)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Bench model built from the requirements, updated at each edge.
    task automatic model_edge();
        logic [W-1:0] cur;
        logic fb, o, rl;
        if (adv) begin
            rl  = !mode && (m_pend || sync);
            cur = rl ? preset : m_state;
            fb  = ^(cur & mask);
            o   = din ^ fb;
            m_state = {cur[W-2:0], mode ? o : fb};
            m_out   = o;
            m_pend  = 1'b0;
        end else if (mode) begin
            m_pend = 1'b0;
        end else if (sync) begin
            m_pend = 1'b1;
        end
    endtask

    task automatic step(input logic a, input logic s, input logic d, input string req);
        @(negedge clk);
        adv = a; sync = s; din = d;
        @(posedge clk);
        #1;
        model_edge();
        check(dout, m_out, req);
    endtask

    task automatic setup(input logic md, input logic [W-1:0] mk, input logic [W-1:0] pr);
        @(negedge clk);
        adv = 1'b0; sync = 1'b0; mode = md; mask = mk; preset = pr;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; adv = 1'b0; sync = 1'b0;
        #1;
        m_state = '0; m_pend = 1'b1; m_out = 1'b0;
        check(dout, 1'b0, "R1 reset output");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_restart();
        do_reset();
        setup(1'b0, 24'h80_0021, 24'hA5_3C96);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, i[0] ^ i[3], "R1 R2 frame after reset");
    endtask

    task automatic t_frame_random();
        setup(1'b0, 24'hE1_0813, 24'h12_3457);
        for (int i = 0; i < 300; i++)
            step(1'b1, (i % 97) == 50, 1'($urandom), "R2 R4 frame stream");
    endtask

    task automatic t_hold();
        setup(1'b0, 24'h5A_C3F1, 24'hF0_0F0F);
        for (int i = 0; i < 60; i++)
            step(1'($urandom_range(0, 2) != 0), 1'b0, 1'($urandom), "R3 hold without advance");
    endtask

    task automatic t_sync_pending();
        setup(1'b0, 24'h90_0005, 24'h6B_1D2E);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, "R4 run up");
        step(1'b0, 1'b1, 1'b0, "R4 sync while idle");
        step(1'b0, 1'b0, 1'b0, "R4 idle");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, "R4 restart after idle");
        step(1'b1, 1'b1, 1'b0, "R4 sync with advance");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, "R4 restart same cycle");
    endtask

    task automatic t_self_sync();
        setup(1'b1, 24'h84_2000, 24'h00_0001);
        for (int i = 0; i < 300; i++)
            step(1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 9) == 0),
                 1'($urandom), "R5 self stream, sync ignored");
        setup(1'b0, 24'h84_2000, 24'hFF_FFFF);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'($urandom), "R5 pending discarded");
    endtask

    task automatic t_zero_mask();
        setup(1'b0, 24'h00_0000, 24'hFF_FFFF);
        step(1'b1, 1'b1, 1'b1, "R6 restart");
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, 1'($urandom), "R6 transparent");
            check(dout, din, "R6 equals input");
        end
    endtask

    task automatic t_top_stage();
        setup(1'b0, 24'h80_0000, 24'h80_0000);
        step(1'b1, 1'b1, 1'b0, "R7 stage 23 tap");
        check(dout, 1'b1, "R7 first bit inverted");
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, "R7 stage 23 walk");
    endtask

    initial begin
        m_state = '0; m_pend = 1'b1; m_out = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_restart();
        t_frame_random();
        t_hold();
        t_sync_pending();
        t_self_sync();
        do_reset();
        t_zero_mask();
        t_top_stage();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule